// File: doc/BRIEF.md
# Banked Shared-Memory Read Conflict Resolver

This block takes a single read request issued by a group of 16 threads to a scratch memory built from 16 banks of 32-bit words. Each thread brings an active bit and a word address. Consecutive word addresses fall in consecutive banks, so a word's bank is its address modulo 16. The row inside that bank is the address shifted right by four.

The block breaks the request into the smallest number of serial passes. In a pass, each bank is read at one row at most. When several pending threads want the very same word, that word is read once and all of those threads are served together. Threads that hit one bank at different words have to wait for later passes.

For every pass, the block presents three things:
- a per-bank enable and row address, which drive the banks;
- a grant mask naming the threads whose data comes back in that pass;
- a flag that marks the final pass.

A new request is taken only once the previous one has issued its last pass.

Top module: `smem_conflict_resolver`

## Requirements
- R1: In a pass, bank `b` is enabled at output bit `b` of `bank_en` only if some granted thread's word address modulo 16 equals `b`. Its row, bits `[28*b +: 28]` of `bank_row`, equals that word address shifted right by 4.
- R2: A request whose active threads all use different banks finishes in exactly one pass, and every active thread is granted in it.
- R3: Active threads that read the same word address are granted in the same pass. A request in which every active thread reads one word takes one pass.
- R4: Active threads that read n different words of one bank are served over n separate passes, one word of that bank per pass.
- R5: In each pass, each bank serves the word of its lowest-numbered pending thread. The grant mask (bit t for thread t) is exactly the pending threads whose word matches the word chosen for their bank.
- R6: The number of passes equals the largest count of distinct words asked of any single bank. `pass_last` is high on the final pass and on no other pass.
- R7: A request with no active threads takes exactly one pass, with an all-zero grant mask and `pass_last` high.
- R8: `req_ready` is low while a request is in progress, and `req_valid` has no effect then. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. Its first pass appears right after that edge. The cycle after the last pass, `pass_valid` is low and `req_ready` is high.
- R9: After reset, `req_ready` is high, `pass_valid` is low and the grant mask is zero.
- R10: Over one request, each active thread is granted in exactly one pass, and inactive threads are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request may be taken |
| req_active | input | 16 | Per-thread active bits, bit t for thread t |
| req_addr | input | 512 | Word addresses, thread t at bits [32*t +: 32] |
| pass_valid | output | 1 | A pass is issued this cycle |
| pass_last | output | 1 | This pass completes the request |
| grant | output | 16 | Threads served by this pass |
| bank_en | output | 16 | Bank read enables, bit b for bank b |
| bank_row | output | 448 | Row address for bank b at bits [28*b +: 28] |

## Verification
The directed cases are chosen so that each one isolates a single rule:
- A unit-stride request shows that distinct banks cost one pass.
- An all-same-word request shows that a broadcast does not split.
- A stride-2 request shows a 2-way conflict, and stride 16 shows a 16-way conflict.
- Eight threads confined to one bank show that only the worst bank sets the pass count.
- An empty request shows the single empty pass.
- A mixed broadcast-and-conflict request, with `req_valid` toggled while the block is busy, shows that the latched request is held.

Random requests draw addresses from few rows, so partial conflicts and broadcasts overlap heavily. Each pass is compared, bank by bank and thread by thread, against a lowest-pending-thread model. The pass count is compared against an independent distinct-words-per-bank count.

// File: rtl/smem_pkg.sv
package smem_pkg;
    localparam int DEF_THREADS = 16;
    localparam int DEF_BANKS   = 16;
    localparam int DEF_ADDR_W  = 32;
endpackage

// File: rtl/smem_bank_pick.sv
// One bank's selector: picks the word of the lowest pending thread mapped to
// this bank and marks every pending thread asking for that same word.
module smem_bank_pick #(
    parameter int THREADS = 16,
    parameter int BANKS   = 16,
    parameter int ADDR_W  = 32,
    parameter int BANK_ID = 0
) (
    input  logic [THREADS-1:0]        pending,
    input  logic [THREADS*ADDR_W-1:0] addr_flat,
    output logic                      en,
    output logic [ADDR_W-$clog2(BANKS)-1:0] row,
    output logic [THREADS-1:0]        take
);
    localparam int BANK_BITS = $clog2(BANKS);
    localparam int ROW_W     = ADDR_W - BANK_BITS;
    localparam logic [BANK_BITS-1:0] MY_BANK = BANK_BITS'(BANK_ID);

    logic [THREADS-1:0] hit;

    always_comb begin
        logic found;
        logic [ADDR_W-1:0] a;
        found = 1'b0;
        row   = '0;
        for (int t = 0; t < THREADS; t++) begin
            a      = addr_flat[t*ADDR_W +: ADDR_W];
            hit[t] = pending[t] && (a[BANK_BITS-1:0] == MY_BANK);
            if (hit[t] && !found) begin
                found = 1'b1;
                row   = a[ADDR_W-1:BANK_BITS];
            end
        end
        for (int t = 0; t < THREADS; t++) begin
            a       = addr_flat[t*ADDR_W +: ADDR_W];
            take[t] = hit[t] && (a[ADDR_W-1:BANK_BITS] == row);
        end
        en = found;
    end
endmodule

// File: rtl/smem_pass_engine.sv
// Builds one full pass from the pending set: one selector per bank, then the
// union of the served threads and the set left for later passes.
module smem_pass_engine #(
    parameter int THREADS = 16,
    parameter int BANKS   = 16,
    parameter int ADDR_W  = 32
) (
    input  logic [THREADS-1:0]        pending,
    input  logic [THREADS*ADDR_W-1:0] addr_flat,
    output logic [BANKS-1:0]          bank_en,
    output logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0] bank_row,
    output logic [THREADS-1:0]        served,
    output logic [THREADS-1:0]        remaining,
    output logic                      final_pass
);
    localparam int ROW_W = ADDR_W - $clog2(BANKS);

    logic [THREADS-1:0] take_by_bank [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        smem_bank_pick #(
            .THREADS(THREADS),
            .BANKS  (BANKS),
            .ADDR_W (ADDR_W),
            .BANK_ID(b)
        ) u_pick (
            .pending  (pending),
            .addr_flat(addr_flat),
            .en       (bank_en[b]),
            .row      (bank_row[b*ROW_W +: ROW_W]),
            .take     (take_by_bank[b])
        );
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | take_by_bank[b];
        end
        remaining  = pending & ~served;
        final_pass = (remaining == '0);
    end
endmodule

// File: rtl/smem_conflict_resolver.sv
module smem_conflict_resolver #(
    parameter int THREADS = smem_pkg::DEF_THREADS,
    parameter int BANKS   = smem_pkg::DEF_BANKS,
    parameter int ADDR_W  = smem_pkg::DEF_ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [THREADS-1:0]        req_active,
    input  logic [THREADS*ADDR_W-1:0] req_addr,
    output logic                      pass_valid,
    output logic                      pass_last,
    output logic [THREADS-1:0]        grant,
    output logic [BANKS-1:0]          bank_en,
    output logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0] bank_row
);
    localparam int ROW_W = ADDR_W - $clog2(BANKS);

    typedef struct packed {
        logic                      busy;
        logic [THREADS-1:0]        pend;
        logic [THREADS*ADDR_W-1:0] addr;
    } state_t;

    state_t state_d, state_q;

    logic [THREADS-1:0]        pend_cur;
    logic [THREADS*ADDR_W-1:0] addr_cur;
    logic [BANKS-1:0]          eng_en;
    logic [BANKS*ROW_W-1:0]    eng_row;
    logic [THREADS-1:0]        eng_served;
    logic [THREADS-1:0]        eng_left;
    logic                      eng_final;

    assign pend_cur = state_q.pend;
    assign addr_cur = state_q.addr;

    smem_pass_engine #(
        .THREADS(THREADS),
        .BANKS  (BANKS),
        .ADDR_W (ADDR_W)
    ) u_engine (
        .pending   (pend_cur),
        .addr_flat (addr_cur),
        .bank_en   (eng_en),
        .bank_row  (eng_row),
        .served    (eng_served),
        .remaining (eng_left),
        .final_pass(eng_final)
    );

    always_comb begin
        state_d = state_q;
        if (!state_q.busy) begin
            if (req_valid) begin
                state_d.busy = 1'b1;
                state_d.pend = req_active;
                state_d.addr = req_addr;
            end
        end else begin
            state_d.pend = eng_left;
            if (eng_final) begin
                state_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        req_ready  = !state_q.busy;
        pass_valid = state_q.busy;
        pass_last  = state_q.busy && eng_final;
        grant      = state_q.busy ? eng_served : '0;
        bank_en    = state_q.busy ? eng_en : '0;
        bank_row   = eng_row;
    end
endmodule

// File: rtl/smem_conflict_resolver_chk.sv
module smem_conflict_resolver_chk #(
    parameter int THREADS = 16,
    parameter int BANKS   = 16,
    parameter int ADDR_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic                      pass_valid,
    input logic                      pass_last,
    input logic [THREADS-1:0]        grant,
    input logic [BANKS-1:0]          bank_en,
    input logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0] bank_row,
    input logic [THREADS-1:0]        pend_cur,
    input logic [THREADS*ADDR_W-1:0] addr_cur
);
    localparam int BANK_BITS = $clog2(BANKS);
    localparam int ROW_W     = ADDR_W - BANK_BITS;

    logic [THREADS-1:0] lowest_pend;
    assign lowest_pend = pend_cur & (~pend_cur + 1'b1);

    // R8: no pass starts without an accepted request
    a_r8_start_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_valid) |-> $past(req_valid && req_ready));

    // R8: busy blocks acceptance
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> !req_ready);

    // R6: the final pass ends the request
    a_r6_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && pass_last) |=> !pass_valid);

    // R6: a non-final pass always serves someone
    a_r6_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && !pass_last) |-> (grant != '0));

    // R10: only pending threads are granted
    a_r10_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> ((grant & ~pend_cur) == '0));

    // R5: the lowest pending thread is always served
    a_r5_lowest_served: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && pend_cur != '0) |-> ((grant & lowest_pend) != '0));

    // R4: served threads leave the pending set
    a_r4_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && !pass_last) |=> (pend_cur == ($past(pend_cur) & ~$past(grant))));

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic [BANK_BITS-1:0] t_bank;
        logic [ROW_W-1:0]     t_row;
        assign t_bank = addr_cur[t*ADDR_W +: BANK_BITS];
        assign t_row  = addr_cur[t*ADDR_W+BANK_BITS +: ROW_W];
        // R1: a granted thread's bank is enabled at its row
        a_r1_route: assert property (@(posedge clk) disable iff (!rst_n)
            (pass_valid && grant[t]) |->
                (bank_en[t_bank] && bank_row[t_bank*ROW_W +: ROW_W] == t_row));
    end
endmodule

bind smem_conflict_resolver smem_conflict_resolver_chk #(
    .THREADS(THREADS),
    .BANKS  (BANKS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .pass_valid(pass_valid),
    .pass_last (pass_last),
    .grant     (grant),
    .bank_en   (bank_en),
    .bank_row  (bank_row),
    .pend_cur  (pend_cur),
    .addr_cur  (addr_cur)
);

// File: tb/smem_conflict_resolver_test.sv
`timescale 1ns/1ps
module smem_conflict_resolver_test;
    localparam int T  = 16;
    localparam int B  = 16;
    localparam int AW = 32;
    localparam int RW = 28;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [T-1:0]    req_active = '0;
    logic [T*AW-1:0] req_addr = '0;
    logic            pass_valid;
    logic            pass_last;
    logic [T-1:0]    grant;
    logic [B-1:0]    bank_en;
    logic [B*RW-1:0] bank_row;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    smem_conflict_resolver uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .pass_valid(pass_valid),
        .pass_last(pass_last), .grant(grant), .bank_en(bank_en), .bank_row(bank_row)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input logic [T*AW-1:0] v, input int t);
        return v[t*AW +: AW];
    endfunction

    function automatic int max_words(input logic [T-1:0] act, input logic [T*AW-1:0] v);
        int cnt [B];
        int best;
        for (int b = 0; b < B; b++) cnt[b] = 0;
        for (int t = 0; t < T; t++) begin
            if (act[t]) begin
                bit dup = 0;
                logic [AW-1:0] a = addr_of(v, t);
                for (int u = 0; u < t; u++) begin
                    if (act[u] && addr_of(v, u) == a) dup = 1;
                end
                if (!dup) cnt[a[3:0]]++;
            end
        end
        best = 0;
        for (int b = 0; b < B; b++) if (cnt[b] > best) best = cnt[b];
        return (best == 0) ? 1 : best;
    endfunction

    task automatic model_pass(input logic [T-1:0] pend, input logic [T*AW-1:0] v,
                              output logic [B-1:0] en, output logic [RW-1:0] rows [B],
                              output logic [T-1:0] g);
        en = '0;
        g  = '0;
        for (int b = 0; b < B; b++) begin
            rows[b] = '0;
            for (int t = T-1; t >= 0; t--) begin
                logic [AW-1:0] a = addr_of(v, t);
                if (pend[t] && a[3:0] == b[3:0]) begin
                    en[b]   = 1'b1;
                    rows[b] = a[AW-1:4];
                end
            end
        end
        for (int t = 0; t < T; t++) begin
            logic [AW-1:0] a = addr_of(v, t);
            if (pend[t] && a[AW-1:4] == rows[a[3:0]]) g[t] = 1'b1;
        end
    endtask

    task automatic run_req(input logic [T-1:0] act, input logic [T*AW-1:0] v,
                           input bit spam, output int npass);
        logic [T-1:0]  pend;
        logic [T-1:0]  seen;
        logic [B-1:0]  e_en;
        logic [RW-1:0] e_rows [B];
        logic [T-1:0]  e_g;
        int exp_passes;
        exp_passes = max_words(act, v);
        @(negedge clk);
        chk("R8 ready when idle", req_ready, 1);
        req_valid  = 1'b1;
        req_active = act;
        req_addr   = v;
        @(posedge clk);
        @(negedge clk);
        if (spam) begin
            req_active = ~act;
            req_addr   = ~v;
        end else begin
            req_valid = 1'b0;
        end
        pend  = act;
        seen  = '0;
        npass = 0;
        forever begin
            model_pass(pend, v, e_en, e_rows, e_g);
            npass++;
            chk("R8 pass_valid", pass_valid, 1);
            chk("R8 ready low busy", req_ready, 0);
            chk("R5 grant", grant, e_g);
            chk("R1 bank_en", bank_en, e_en);
            for (int b = 0; b < B; b++) begin
                if (e_en[b]) chk("R1 bank_row", bank_row[b*RW +: RW], e_rows[b]);
            end
            pend = pend & ~e_g;
            seen = seen | grant;
            chk("R6 pass_last", pass_last, (pend == '0));
            if (pend == '0 || npass > T) begin
                req_valid = 1'b0;
                break;
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk("R6 pass count", npass, exp_passes);
        chk("R10 each active once", seen, act);
        @(posedge clk);
        @(negedge clk);
        chk("R8 idle after last", pass_valid, 0);
        chk("R8 ready after last", req_ready, 1);
    endtask

    function automatic logic [T*AW-1:0] stride(input int base, input int step);
        logic [T*AW-1:0] v;
        for (int t = 0; t < T; t++) v[t*AW +: AW] = AW'(base + t*step);
        return v;
    endfunction

    initial begin
        int n;
        logic [T*AW-1:0] v;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset ready", req_ready, 1);
        chk("R9 reset no pass", pass_valid, 0);
        chk("R9 reset grant", grant, 0);

        run_req('1, stride(5, 1), 0, n);
        chk("R2 unit stride one pass", n, 1);

        run_req('1, stride(77, 0), 0, n);
        chk("R3 broadcast one pass", n, 1);

        run_req('1, stride(0, 2), 0, n);
        chk("R4 stride two passes", n, 2);

        v = stride(0, 16);
        for (int t = 8; t < T; t++) v[t*AW +: AW] = AW'(t);
        run_req('1, v, 0, n);
        chk("R4 eight-way bank", n, 8);

        run_req('1, stride(3, 16), 0, n);
        chk("R4 sixteen-way", n, 16);

        run_req('0, stride(9, 1), 0, n);
        chk("R7 empty one pass", n, 1);

        v = stride(0, 1);
        for (int t = 0; t < 8; t++) v[t*AW +: AW] = 32'd160;
        v[9*AW +: AW] = 32'd48;
        v[10*AW +: AW] = 32'd96;
        run_req(16'hF6FF, v, 1, n);
        chk("R3 R4 mixed with busy valid", n, 3);

        run_req(16'h0001, stride(4095, 1), 1, n);
        chk("R2 single thread", n, 1);

        for (int i = 0; i < 300; i++) begin
            logic [T-1:0] act;
            act = T'($urandom);
            if (i % 5 == 0) act = '1;
            for (int t = 0; t < T; t++) begin
                v[t*AW +: AW] = {26'($urandom_range(0, 2)), 2'b00, 4'($urandom)};
            end
            run_req(act, v, bit'($urandom_range(0, 1)), n);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule